// File: doc/BRIEF.md
# Compare-Driven PWM Output Channel

This block is a single compare output channel. It belongs beside a time-base counter. On every clock it takes the counter's value and direction and compares them with an active compare value. A registered reference waveform comes out of that comparison, and it is shaped by a 3-bit mode. The modes are:

- hold the current level
- set on match
- clear on match
- toggle on match
- force low
- force high
- two complementary PWM senses

A polarity bit and an enable turn the reference into a pin level. A separate one-clock flag marks every cycle in which the count equals the compare value.

The compare value is double-buffered. A new value arrives through a valid/ready write port and lands in a preload register. It becomes active only when the time base signals an update event, so a PWM period is never cut by a mid-period change. The write port never applies back-pressure: `cmp_ready_o` is always 1, and each cycle with `cmp_valid_i` high is one accepted write. If a write and an update fall in the same cycle, the written value goes straight to the active register.

Paired with an up-counting time base, the PWM senses give left-aligned pulses (sense 1) and right-aligned pulses (sense 2). Paired with an up/down time base, they give centred pulses. While the counter reports down-counting, the PWM threshold moves by one count, which keeps centre-aligned pulses symmetric about the counter peak.

Top module: `ocp_channel`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the reference is low, the match flag is 0 and the active compare value is 0. With `out_en_i`=1 and `pol_i`=0, the pin is therefore 0.
- R2: Mode 3'b000 holds the reference at its current level whatever the count is.
- R3: Mode 3'b001 sets the reference high in the cycle after the count equals the compare value. Mode 3'b010 clears it low in that cycle. In all other cycles both modes hold the reference.
- R4: Mode 3'b011 inverts the reference in the cycle after each count equal to the compare value, and holds it otherwise.
- R5: Mode 3'b100 drives the reference low, and mode 3'b101 drives it high, one cycle after the mode is applied.
- R6: In mode 3'b110 (PWM sense 1) with `cnt_down_i`=0, the reference is active when count < compare and inactive otherwise. With up-counting, reload 6 and compare 3, it is active for 3 of every 7 clocks.
- R7: In mode 3'b111 (PWM sense 2) with `cnt_down_i`=0, the reference is active when count ≥ compare. With reload 6 and compare 3, it is active for 4 of every 7 clocks.
- R8: With `pol_i`=0, an active reference drives the pin high. With `pol_i`=1, it drives the pin low.
- R9: With `out_en_i`=0, the pin sits at the inactive level, which equals `pol_i`, whatever the reference is.
- R10: A value written through the compare port does not affect matching or PWM until an update event (`upd_i`=1). Without an update, the active compare value stays unchanged.
- R11: `match_o` is 1 for exactly the cycle after each cycle in which the count equals the active compare value, in every mode.
- R12: While `cnt_down_i`=1, PWM sense 1 is active when count ≤ compare and PWM sense 2 is active when count > compare. Up/down counting 0..6..1 with compare 3 gives sense 2 an active time of 6 of 12 clocks. That pulse begins when the up-count reaches 3 and ends when the down-count reaches 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_i | input | CNT_W | Time-base count |
| cnt_down_i | input | 1 | 1 while the time base counts down |
| upd_i | input | 1 | Time-base update event, one cycle |
| cmp_valid_i | input | 1 | Compare write valid |
| cmp_ready_o | output | 1 | Compare write ready (always 1) |
| cmp_data_i | input | CNT_W | Compare write value |
| mode_i | input | 3 | Output mode code |
| pol_i | input | 1 | 0: active drives high, 1: active drives low |
| out_en_i | input | 1 | Pin drive enable |
| pin_o | output | 1 | Output pin level |
| match_o | output | 1 | Compare-match flag |

## Verification
The hardest situation to reach is a preload that differs from the active compare value while the count passes through the new value. From the ports alone, that state can be seen only as the absence of a match. The stimulus first makes 3 active. It then writes 5 with no update and steps the count through 5 in set-on-match mode, expecting neither a flag nor a pin change. Next it steps through 3 and expects a flag. Only then does it pulse the update alone and expect the match at 5. The centre-aligned case is reached by driving the count up and down by hand, with the direction bit switched at the peak.

// File: rtl/ocp_pkg.sv
package ocp_pkg;
  typedef enum logic [2:0] {
    OCM_HOLD   = 3'b000,
    OCM_SET    = 3'b001,
    OCM_CLR    = 3'b010,
    OCM_TOGGLE = 3'b011,
    OCM_LOW    = 3'b100,
    OCM_HIGH   = 3'b101,
    OCM_PWM1   = 3'b110,
    OCM_PWM2   = 3'b111
  } ocm_e;

  typedef struct packed {
    logic eq;
    logic lt;
    logic gt;
  } cmp_res_t;
endpackage

// File: rtl/ocp_cmp_shadow.sv
module ocp_cmp_shadow #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             upd_i,
  output logic [CNT_W-1:0] cmp_act_o
);
  logic [CNT_W-1:0] pre_q;
  logic [CNT_W-1:0] act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      act_q <= '0;
    end else begin
      if (wr_valid_i) pre_q <= wr_data_i;
      if (upd_i)      act_q <= wr_valid_i ? wr_data_i : pre_q;
    end
  end

  assign cmp_act_o = act_q;
endmodule

// File: rtl/ocp_ref_gen.sv
module ocp_ref_gen
  import ocp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             cnt_down_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic [2:0]       mode_i,
  output logic             ref_o,
  output logic             match_o
);
  cmp_res_t res;
  logic     pwm1_act;
  logic     ref_d;
  logic     ref_q;
  logic     match_q;

  always_comb begin
    res.eq = (cnt_i == cmp_i);
    res.lt = (cnt_i <  cmp_i);
    res.gt = (cnt_i >  cmp_i);
  end

  // Down-counting moves the PWM threshold by one for centred pulses.
  assign pwm1_act = cnt_down_i ? !res.gt : res.lt;

  always_comb begin
    ref_d = ref_q;
    unique case (ocm_e'(mode_i))
      OCM_HOLD:   ref_d = ref_q;
      OCM_SET:    if (res.eq) ref_d = 1'b1;
      OCM_CLR:    if (res.eq) ref_d = 1'b0;
      OCM_TOGGLE: if (res.eq) ref_d = !ref_q;
      OCM_LOW:    ref_d = 1'b0;
      OCM_HIGH:   ref_d = 1'b1;
      OCM_PWM1:   ref_d = pwm1_act;
      OCM_PWM2:   ref_d = !pwm1_act;
      default:    ref_d = ref_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q   <= 1'b0;
      match_q <= 1'b0;
    end else begin
      ref_q   <= ref_d;
      match_q <= res.eq;
    end
  end

  assign ref_o   = ref_q;
  assign match_o = match_q;
endmodule

// File: rtl/ocp_pin_stage.sv
module ocp_pin_stage (
  input  logic ref_i,
  input  logic pol_i,
  input  logic en_i,
  output logic pin_o
);
  logic active_lvl;
  logic idle_lvl;

  assign active_lvl = ref_i ^ pol_i;
  assign idle_lvl   = pol_i;
  assign pin_o      = en_i ? active_lvl : idle_lvl;
endmodule

// File: rtl/ocp_channel.sv
module ocp_channel #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             cnt_down_i,
  input  logic             upd_i,
  input  logic             cmp_valid_i,
  output logic             cmp_ready_o,
  input  logic [CNT_W-1:0] cmp_data_i,
  input  logic [2:0]       mode_i,
  input  logic             pol_i,
  input  logic             out_en_i,
  output logic             pin_o,
  output logic             match_o
);
  logic [CNT_W-1:0] cmp_act;
  logic             ref_q;

  assign cmp_ready_o = 1'b1;

  ocp_cmp_shadow #(.CNT_W(CNT_W)) u_shadow (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_valid_i(cmp_valid_i),
    .wr_data_i (cmp_data_i),
    .upd_i     (upd_i),
    .cmp_act_o (cmp_act)
  );

  ocp_ref_gen #(.CNT_W(CNT_W)) u_ref (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_i     (cnt_i),
    .cnt_down_i(cnt_down_i),
    .cmp_i     (cmp_act),
    .mode_i    (mode_i),
    .ref_o     (ref_q),
    .match_o   (match_o)
  );

  ocp_pin_stage u_pin (
    .ref_i(ref_q),
    .pol_i(pol_i),
    .en_i (out_en_i),
    .pin_o(pin_o)
  );
endmodule

// File: rtl/ocp_channel_chk.sv
module ocp_channel_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] cnt_i,
  input logic             cnt_down_i,
  input logic             upd_i,
  input logic [2:0]       mode_i,
  input logic             pol_i,
  input logic             out_en_i,
  input logic             pin_o,
  input logic             match_o,
  input logic [CNT_W-1:0] cmp_act
);
  logic run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= 1'b1;
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    run_q && $past(mode_i == 3'b000) && $stable(out_en_i) && $stable(pol_i) |-> $stable(pin_o)); // R2
  AST_FORCE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    run_q && $past(mode_i == 3'b100) && out_en_i && !pol_i |-> !pin_o); // R5
  AST_PWM1_UP: assert property (@(posedge clk) disable iff (!rst_n)
    run_q && $past(mode_i == 3'b110 && !cnt_down_i) && out_en_i && !pol_i |-> pin_o == $past(cnt_i < cmp_act)); // R6
  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    run_q && !$past(upd_i) |-> $stable(cmp_act)); // R10
  AST_MATCH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> match_o == $past(cnt_i == cmp_act)); // R11
endmodule

bind ocp_channel ocp_channel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cnt_i     (cnt_i),
  .cnt_down_i(cnt_down_i),
  .upd_i     (upd_i),
  .mode_i    (mode_i),
  .pol_i     (pol_i),
  .out_en_i  (out_en_i),
  .pin_o     (pin_o),
  .match_o   (match_o),
  .cmp_act   (cmp_act)
);

// File: tb/ocp_channel_tb.sv
module ocp_channel_tb_top;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] cnt_i = '0;
  logic          cnt_down_i = 1'b0;
  logic          upd_i = 1'b0;
  logic          cmp_valid_i = 1'b0;
  logic          cmp_ready_o;
  logic [CW-1:0] cmp_data_i = '0;
  logic [2:0]    mode_i = 3'b100;
  logic          pol_i = 1'b0;
  logic          out_en_i = 1'b1;
  logic          pin_o;
  logic          match_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  ocp_channel #(.CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cnt_i(cnt_i), .cnt_down_i(cnt_down_i),
    .upd_i(upd_i), .cmp_valid_i(cmp_valid_i), .cmp_ready_o(cmp_ready_o),
    .cmp_data_i(cmp_data_i), .mode_i(mode_i), .pol_i(pol_i),
    .out_en_i(out_en_i), .pin_o(pin_o), .match_o(match_o)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_int(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Apply a count for one clock; on return outputs reflect it.
  task automatic step(input int c, input logic down);
    @(negedge clk);
    cnt_i = CW'(c);
    cnt_down_i = down;
    @(posedge clk);
    #1;
  endtask

  task automatic load_cmp(input int v);
    @(negedge clk);
    cmp_data_i = CW'(v); cmp_valid_i = 1'b1; upd_i = 1'b1;
    @(posedge clk); #1;
    cmp_valid_i = 1'b0; upd_i = 1'b0;
  endtask

  task automatic force_ref(input logic lvl);
    mode_i = lvl ? 3'b101 : 3'b100;
    step(9, 1'b0);
  endtask

  task automatic t_reset();
    #1;
    check("R1 pin in reset", pin_o, 1'b0);
    check("R1 flag in reset", match_o, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 pin after reset", pin_o, 1'b0);
    mode_i = 3'b001;
    step(0, 1'b0);
    check("R1 active compare 0 matches", match_o, 1'b1);
  endtask

  task automatic t_forced();
    mode_i = 3'b101; step(2, 1'b0);
    check("R5 force high", pin_o, 1'b1);
    mode_i = 3'b100; step(2, 1'b0);
    check("R5 force low", pin_o, 1'b0);
  endtask

  task automatic t_set_clear();
    load_cmp(3);
    force_ref(1'b0);
    mode_i = 3'b001;
    for (int c = 0; c < 3; c++) begin
      step(c, 1'b0);
      check("R3 set mode no match", pin_o, 1'b0);
      check("R11 no flag", match_o, 1'b0);
    end
    step(3, 1'b0);
    check("R3 set on match", pin_o, 1'b1);
    check("R11 flag on match", match_o, 1'b1);
    step(4, 1'b0);
    check("R3 set holds", pin_o, 1'b1);
    check("R11 flag one clock", match_o, 1'b0);
    mode_i = 3'b010;
    step(1, 1'b0);
    check("R3 clear mode holds", pin_o, 1'b1);
    step(3, 1'b0);
    check("R3 clear on match", pin_o, 1'b0);
    check("R11 flag in clear mode", match_o, 1'b1);
  endtask

  task automatic t_toggle();
    logic exp;
    load_cmp(3);
    force_ref(1'b0);
    mode_i = 3'b011;
    exp = 1'b0;
    for (int p = 0; p < 2; p++)
      for (int c = 0; c <= 6; c++) begin
        step(c, 1'b0);
        if (c == 3) exp = !exp;
        check("R4 toggle", pin_o, exp);
      end
  endtask

  task automatic t_hold();
    load_cmp(3);
    force_ref(1'b1);
    mode_i = 3'b000;
    for (int c = 0; c <= 6; c++) begin
      step(c, 1'b0);
      check("R2 hold high", pin_o, 1'b1);
    end
    force_ref(1'b0);
    mode_i = 3'b000;
    step(3, 1'b0);
    check("R2 hold low", pin_o, 1'b0);
  endtask

  task automatic t_pwm_up();
    int act1, act2;
    load_cmp(3);
    mode_i = 3'b110; act1 = 0;
    for (int c = 0; c <= 6; c++) begin
      step(c, 1'b0);
      check("R6 pwm1 level", pin_o, c < 3);
      act1 += int'(pin_o);
    end
    check_int("R6 pwm1 active clocks", act1, 3);
    mode_i = 3'b111; act2 = 0;
    for (int c = 0; c <= 6; c++) begin
      step(c, 1'b0);
      check("R7 pwm2 level", pin_o, c >= 3);
      act2 += int'(pin_o);
    end
    check_int("R7 pwm2 active clocks", act2, 4);
  endtask

  task automatic t_center();
    int act;
    load_cmp(3);
    mode_i = 3'b111;
    for (int p = 0; p < 2; p++) begin
      act = 0;
      for (int i = 0; i < 12; i++) begin
        int c = (i <= 6) ? i : 12 - i;
        logic dn = (i > 6);
        step(c, dn);
        check("R12 center pwm2 level", pin_o, dn ? (c > 3) : (c >= 3));
        act += int'(pin_o);
      end
      check_int("R12 center active clocks", act, 6);
    end
    mode_i = 3'b110;
    step(3, 1'b1);
    check("R12 pwm1 down at compare", pin_o, 1'b1);
    step(4, 1'b1);
    check("R12 pwm1 down above compare", pin_o, 1'b0);
  endtask

  task automatic t_polarity();
    pol_i = 1'b1;
    mode_i = 3'b101; step(0, 1'b0);
    check("R8 active drives low", pin_o, 1'b0);
    mode_i = 3'b100; step(0, 1'b0);
    check("R8 inactive drives high", pin_o, 1'b1);
    pol_i = 1'b0;
  endtask

  task automatic t_disable();
    mode_i = 3'b101; step(0, 1'b0);
    out_en_i = 1'b0; #1;
    check("R9 disabled pol0", pin_o, 1'b0);
    pol_i = 1'b1; #1;
    check("R9 disabled pol1", pin_o, 1'b1);
    pol_i = 1'b0; out_en_i = 1'b1; #1;
    check("R9 re-enabled", pin_o, 1'b1);
  endtask

  task automatic t_shadow();
    load_cmp(3);
    force_ref(1'b0);
    @(negedge clk);
    cmp_data_i = CW'(5); cmp_valid_i = 1'b1;
    @(posedge clk); #1;
    cmp_valid_i = 1'b0;
    mode_i = 3'b001;
    step(5, 1'b0);
    check("R10 preload no match flag", match_o, 1'b0);
    check("R10 preload no set", pin_o, 1'b0);
    step(3, 1'b0);
    check("R10 old compare still active", match_o, 1'b1);
    mode_i = 3'b100; step(0, 1'b0);
    @(negedge clk); upd_i = 1'b1;
    @(posedge clk); #1; upd_i = 1'b0;
    mode_i = 3'b001;
    step(5, 1'b0);
    check("R10 new compare after update", match_o, 1'b1);
    check("R10 set at new compare", pin_o, 1'b1);
  endtask

  initial begin
    t_reset();
    t_forced();
    t_set_clear();
    t_toggle();
    t_hold();
    t_pwm_up();
    t_center();
    t_polarity();
    t_disable();
    t_shadow();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule